// File: doc/BRIEF.md
# Parallel Memory Cycle Controller

This controller sits on the host side of a byte-wide memory that latches its address on the falling edge of chip enable. It turns single read or write requests into a fixed sequence of active-low chip enable, output enable and write enable strobes. It also drives the address and the bidirectional data bus through split in, out and enable signals. Every cycle has the same length for reads and writes. Every cycle ends with chip enable held high for a precharge interval, so the cycle time is longer than the access time. A write completes inside its bus cycle, and no status polling is needed.

A request is taken when `req_valid` is high while the controller is idle. The operation, address, write data and write mode are captured at that edge. Inputs that change while a cycle is running have no effect on it. A configuration input selects one of two write forms. In the first, write enable is already low when chip enable falls. In the second, chip enable falls first and write enable falls later. The end of the cycle is signalled by a one-clock `rsp_done` pulse. For a read, the data is already on `rsp_rdata` when `rsp_done` is high.

Timing is counted in clocks with parameters: address setup `T_ASU`=1, access `T_ACC`=4, data setup `T_DSU`=2 and precharge `T_PRE`=2. In the requirements, clock k means the k-th rising edge after the edge that accepts a request (k=0 is the accepting edge). The values are those seen after that edge.

Top module: `memcyc_ctrl`

## Requirements
- R1: While reset is low and right after it is released, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: A request is accepted only while `req_ready` is 1. `req_ready` is 0 after clocks 0 to 6 and is 1 again after clock 7. Changes to `req_valid`, `req_write`, `req_addr`, `req_wdata` or `cfg_we_mode` after clock 0 do not alter the running cycle.
- R3: `mem_addr` equals the accepted address from clock 0 through clock 6. `mem_ce_n` goes low after clock 1, one clock after the address appears. The address does not change while `mem_ce_n` is low.
- R4: On a read (`req_write`=0), `mem_ce_n` and `mem_oe_n` are both 0 after clocks 1 to 4. `mem_we_n` stays 1 and `mem_dq_oe` stays 0. The value of `mem_dq_i` at clock 5 is placed on `rsp_rdata`, where it is valid while `rsp_done` is 1.
- R5: A write with `cfg_we_mode`=0 is framed by chip enable. `mem_we_n` is 0 after clocks 0 to 4, so it falls one clock before `mem_ce_n`. `mem_ce_n` is 0 after clocks 1 to 4, and `mem_oe_n` stays 1.
- R6: A write with `cfg_we_mode`=1 is framed by write enable. `mem_ce_n` is 0 after clocks 1 to 4 and `mem_we_n` is 1 after clocks 1 and 2. `mem_we_n` is 0 after clocks 3 and 4 and rises together with `mem_ce_n`. `mem_oe_n` stays 1.
- R7: `mem_dq_oe` is 1 only after clocks 3 and 4 of a write, with `mem_dq_o` equal to the accepted write data. Data is therefore held for 2 clocks before the strobes rise. `mem_dq_oe` and a low `mem_oe_n` never coincide.
- R8: After every cycle `mem_ce_n` is 1 for at least 2 clocks (after clocks 5 and 6) before it can fall again. Reads and writes take the same 7 clocks from acceptance to `rsp_done`.
- R9: `rsp_done` is 1 for exactly one clock, after clock 7, and only at the end of a precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_mode | input | 1 | Write form: 0 framed by chip enable, 1 framed by write enable |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, a request is taken this clock |
| rsp_rdata | output | 8 | Data returned by the last read |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 13 | Memory address |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
Some properties are checked by assertions on every clock:
- the controller never drives the bus while output enable is low;
- output enable is low only while chip enable is low;
- the address is frozen while chip enable is low;
- chip enable stays high for two clocks after each rise;
- write enable in the chip-enable form is already low one clock before chip enable falls;
- write enable rises only together with chip enable;
- the done pulse lasts one clock and follows the precharge state.

Other behaviours only the directed scenarios can show:
- the exact clock-by-clock strobe profile in each mode;
- that inputs changed during a cycle are ignored;
- that data written in either mode reads back from a bench memory model.

// File: rtl/memcyc_pkg.sv
// Shared types for the parallel memory cycle controller.
package memcyc_pkg;

    // Phases of one memory cycle.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACCESS = 3'd2,
        ST_WEND   = 3'd3,
        ST_PRE    = 3'd4
    } cyc_state_e;

endpackage

// File: rtl/memcyc_seq.sv
// Cycle sequencer: walks IDLE -> SETUP -> ACCESS -> (WEND) -> PRECHARGE.
// A write splits the access interval into ACCESS (T_ACC-T_DSU clocks)
// and WEND (T_DSU clocks), so reads and writes last equally long.
// Assumes T_ASU, T_PRE >= 1 and 1 <= T_DSU < T_ACC. op_wr must be the
// latched operation, valid from the clock after acceptance.
module memcyc_seq
    import memcyc_pkg::*;
#(
    parameter int T_ASU = 1,
    parameter int T_ACC = 4,
    parameter int T_DSU = 2,
    parameter int T_PRE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       op_wr,
    output logic       accept,
    output cyc_state_e st_q,
    output cyc_state_e st_d,
    output logic       sample,
    output logic       done
);
    localparam int TM1 = (T_ASU > T_ACC) ? T_ASU : T_ACC;
    localparam int TMX = (TM1 > T_PRE) ? TM1 : T_PRE;
    localparam int CW  = $clog2(TMX + 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          last;

    assign last   = (cnt_q == '0);
    assign accept = (st_q == ST_IDLE) && req_valid;
    assign sample = (st_q == ST_ACCESS) && !op_wr && last;

    // Next phase and the length of that phase.
    always_comb begin
        st_d  = st_q;
        cnt_d = last ? cnt_q : cnt_q - 1'b1;
        unique case (st_q)
            ST_IDLE: if (accept) begin
                st_d  = ST_SETUP;
                cnt_d = CW'(T_ASU - 1);
            end
            ST_SETUP: if (last) begin
                st_d  = ST_ACCESS;
                cnt_d = op_wr ? CW'(T_ACC - T_DSU - 1) : CW'(T_ACC - 1);
            end
            ST_ACCESS: if (last) begin
                st_d  = op_wr ? ST_WEND : ST_PRE;
                cnt_d = op_wr ? CW'(T_DSU - 1) : CW'(T_PRE - 1);
            end
            ST_WEND: if (last) begin
                st_d  = ST_PRE;
                cnt_d = CW'(T_PRE - 1);
            end
            ST_PRE: if (last) begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // Phase register, phase counter and the end-of-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            done  <= (st_q == ST_PRE) && last;
        end
    end

    // R9: the done pulse lasts a single clock
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows the final clock of the precharge phase
    p_done_after_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st_q) == ST_PRE));

endmodule

// File: rtl/memcyc_pins.sv
// Memory pin stage: registers every strobe from the next phase so the
// pins change only at clock edges. Captures the address and write data
// on acceptance and captures read data when the sequencer says so.
// Assumes wr_d and wem_d already show the operation being accepted.
module memcyc_pins
    import memcyc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  cyc_state_e        st_d,
    input  logic              wr_d,
    input  logic              wem_d,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic ce_on, oe_on, we_on, dq_on;

    // Strobe levels wanted for the phase about to start.
    always_comb begin
        ce_on = (st_d == ST_ACCESS) || (st_d == ST_WEND);
        oe_on = (st_d == ST_ACCESS) && !wr_d;
        if (wem_d)
            we_on = wr_d && (st_d == ST_WEND);
        else
            we_on = wr_d && ((st_d == ST_SETUP) || ce_on);
        dq_on = wr_d && (st_d == ST_WEND);
    end

    // Strobe, address, data and read-capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            mem_addr  <= '0;
            mem_dq_o  <= '0;
            rsp_rdata <= '0;
        end else begin
            mem_ce_n  <= !ce_on;
            mem_oe_n  <= !oe_on;
            mem_we_n  <= !we_on;
            mem_dq_oe <= dq_on;
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
            end
            if (sample)
                rsp_rdata <= mem_dq_i;
        end
    end

    // R7: the controller never drives while the memory may drive
    p_no_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R4: output enable only inside a chip-enable window
    p_oe_in_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    // R3: the address is frozen while chip enable is low
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> $stable(mem_addr));

    // R8: chip enable stays high for a precharge of two clocks
    p_pre_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |=> mem_ce_n);

    // R5: write enable low at the chip-enable fall was already low before
    p_ce_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && !mem_we_n) |-> ($past(mem_we_n) == 1'b0));

    // R6: a write ends with write enable and chip enable rising together
    p_we_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_ce_n));

endmodule

// File: rtl/memcyc_ctrl.sv
// Parallel memory cycle controller top. It accepts one request while
// idle and latches its operation and write form. It runs the sequencer
// and the pin stage, and reports completion with a one-clock pulse.
// Assumes the memory needs no polling: a write is complete at cycle end.
module memcyc_ctrl
    import memcyc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int T_ASU  = 1,
    parameter int T_ACC  = 4,
    parameter int T_DSU  = 2,
    parameter int T_PRE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    cyc_state_e st_q, st_d;
    logic       accept, sample;
    logic       cur_wr, cur_wem;
    logic       wr_d, wem_d;

    assign req_ready = (st_q == ST_IDLE);
    assign wr_d      = accept ? req_write   : cur_wr;
    assign wem_d     = accept ? cfg_we_mode : cur_wem;

    // Hold the operation and write form for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wr  <= 1'b0;
            cur_wem <= 1'b0;
        end else if (accept) begin
            cur_wr  <= req_write;
            cur_wem <= cfg_we_mode;
        end
    end

    memcyc_seq #(
        .T_ASU(T_ASU), .T_ACC(T_ACC), .T_DSU(T_DSU), .T_PRE(T_PRE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .op_wr    (cur_wr),
        .accept   (accept),
        .st_q     (st_q),
        .st_d     (st_d),
        .sample   (sample),
        .done     (rsp_done)
    );

    memcyc_pins #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .st_d     (st_d),
        .wr_d     (wr_d),
        .wem_d    (wem_d),
        .sample   (sample),
        .mem_dq_i (mem_dq_i),
        .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n),
        .mem_addr (mem_addr),
        .mem_dq_o (mem_dq_o),
        .mem_dq_oe(mem_dq_oe),
        .rsp_rdata(rsp_rdata)
    );

    // R2: a request is taken only from the idle phase
    p_ready_low_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: tb/tb_memcyc_ctrl.sv
// Directed bench: a behavioural byte memory that latches the address on
// the chip-enable fall, plus one task per scenario.
module tb_memcyc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [12:0] mem_addr;
    logic [7:0]  mem_dq_o, mem_dq_i;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    memcyc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_mode(cfg_we_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: 256 bytes indexed by the low address byte.
    logic [7:0]  mem [256];
    logic [7:0]  shadow [256];
    logic [12:0] lat = '0;
    logic        pce = 1'b1, pwe = 1'b1;
    logic [7:0]  pdq = '0;
    int          clash = 0;

    initial for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end

    assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? mem[lat[7:0]] : 8'hEE;

    always @(negedge clk) begin
        if (pce && !mem_ce_n) lat = mem_addr;
        if (!pce && !pwe && (mem_ce_n || mem_we_n)) mem[lat[7:0]] = pdq;
        if (mem_dq_oe && !mem_oe_n) clash++;
        pce = mem_ce_n;
        pwe = mem_we_n;
        pdq = mem_dq_o;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: reset state of every output.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done, req_ready},
              6'b111001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done, req_ready},
              6'b111001);
    endtask

    // One cycle; inputs are scrambled while busy to show they are ignored (R2).
    task automatic run_op(bit wr, bit wem, logic [12:0] a, logic [7:0] d);
        string tag;
        tag = !wr ? "R4 read" : (wem ? "R6 we-framed write" : "R5 ce-framed write");
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; cfg_we_mode = wem;
        @(posedge clk);
        for (int k = 0; k <= 7; k++) begin
            logic exp_ce, exp_oe, exp_we, exp_dqoe, exp_done, exp_rdy;
            @(negedge clk);
            if (k == 0) begin
                req_write = ~wr; req_addr = ~a; req_wdata = ~d; cfg_we_mode = ~wem;
            end
            if (k == 6) req_valid = 1'b0;
            exp_ce   = !(k >= 1 && k <= 4);
            exp_oe   = !(!wr && k >= 1 && k <= 4);
            exp_we   = !(wr && ((!wem && k <= 4) || (wem && k >= 3 && k <= 4)));
            exp_dqoe = wr && (k == 3 || k == 4);
            exp_done = (k == 7);
            exp_rdy  = (k == 7);
            check($sformatf("%s R7 R8 R9 profile k=%0d", tag, k),
                  {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done, req_ready},
                  {exp_ce, exp_oe, exp_we, exp_dqoe, exp_done, exp_rdy});
            if (k <= 6)
                check($sformatf("R3 R2 address k=%0d", k), mem_addr, a);
            if (exp_dqoe)
                check($sformatf("R7 write data k=%0d", k), mem_dq_o, d);
            if (k == 7 && !wr)
                check("R4 read data", rsp_rdata, shadow[a[7:0]]);
        end
        if (wr) shadow[a[7:0]] = d;
    endtask

    task automatic t_ce_write_read();
        run_op(1'b1, 1'b0, 13'h00A5, 8'h3C);
        run_op(1'b0, 1'b0, 13'h00A5, 8'h00);
    endtask

    task automatic t_we_write_read();
        run_op(1'b1, 1'b1, 13'h1F12, 8'hC3);
        run_op(1'b0, 1'b1, 13'h1F12, 8'h00);
    endtask

    task automatic t_unwritten_and_overwrite();
        run_op(1'b0, 1'b0, 13'h0077, 8'h00);
        run_op(1'b1, 1'b1, 13'h00A5, 8'h5A);
        run_op(1'b0, 1'b1, 13'h00A5, 8'h00);
    endtask

    task automatic t_top_address();
        run_op(1'b1, 1'b0, 13'h1FFF, 8'h81);
        run_op(1'b0, 1'b0, 13'h1FFF, 8'h00);
    endtask

    initial begin
        t_reset();
        t_ce_write_read();
        t_we_write_read();
        t_unwritten_and_overwrite();
        t_top_address();
        check("R7 bus clash count", clash, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule